// File: doc/BRIEF.md
# Two-by-Two Packet Switch with Statistics

The block sits between two input packet queues and two output packet queues. In each cycle it looks at the packet at the head of each input queue and routes it to one of the two output queues. A destination bit inside each packet picks the output. A second bit marks a packet as one to be counted. A single shared counter records how many marked packets have passed through the switch.

Each input presents its head packet with a valid bit. The switch answers with a take strobe in the same cycle, which pops that queue. Each output queue reports with a room bit that it is not full. The switch answers with a write strobe and the packet data in the same cycle. The routing is purely combinational. Only the statistics counter holds state.

Two shared resources can collide: an output queue, and the counter. Both collisions are settled in favour of input 1. Every other packet that is able to move moves in the same cycle, so no cycle is lost.

Top module: `pkt_switch2x2`

## Requirements
- R1: Bit 0 of a packet selects its output. A value of 0 sends it to output 1 (port `x`) and a value of 1 sends it to output 2 (port `y`). The data reaches the output unchanged.
- R2: Bit 1 of a packet is the counted flag. The counter rises by exactly one for every moved packet whose flag is 1, and it does not change for moved packets whose flag is 0.
- R3: A packet is taken only when its input is valid and its chosen output reports room. A write strobe is never raised toward an output without room, and no take strobe is raised on an input that is not valid.
- R4: An input 1 packet whose output has room always moves in that cycle, whatever input 2 holds.
- R5: If both inputs hold packets for the same output and that output has room, only the input 1 packet moves. The input 2 packet stays.
- R6: If both inputs move to different outputs and both packets are flagged, only the input 1 packet moves. The input 2 packet stays.
- R7: In every other case an input 2 packet whose output has room moves in the same cycle as the input 1 packet. This covers the case where input 1 is empty or blocked.
- R8: A packet is popped from its input in the same cycle in which it is written to its output.
- R9: The counter is CNT_W bits wide (default 32). It reads zero after reset and wraps to zero past its largest value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the counter |
| a_valid | input | 1 | Input 1 queue holds a packet |
| a_data | input | DATA_W | Input 1 head packet |
| a_take | output | 1 | Pop input 1 this cycle |
| b_valid | input | 1 | Input 2 queue holds a packet |
| b_data | input | DATA_W | Input 2 head packet |
| b_take | output | 1 | Pop input 2 this cycle |
| x_room | input | 1 | Output 1 queue is not full |
| x_write | output | 1 | Push into output 1 this cycle |
| x_data | output | DATA_W | Packet for output 1 |
| y_room | input | 1 | Output 2 queue is not full |
| y_write | output | 1 | Push into output 2 this cycle |
| y_data | output | DATA_W | Packet for output 2 |
| hit_count | output | CNT_W | Count of flagged packets moved |

## Verification
The bench aims at the two collision cases. A switch that let both inputs write the same output would raise two pushes at once and lose a packet. A switch that ignored the counter conflict would move both flagged packets and under-count by one. It also blocks input 1 on a full output and checks that input 2 then moves, since a design that stalls input 2 whenever input 1 stalls would lose throughput. Finally, with a narrow counter, it drives the count across its top value to show the wrap back to zero.

// File: rtl/pkt_switch2x2.sv
module pkt_switch2x2 #(
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int DEST_BIT = 0,
  parameter int FLAG_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_valid,
  input  logic [DATA_W-1:0] a_data,
  output logic              a_take,
  input  logic              b_valid,
  input  logic [DATA_W-1:0] b_data,
  output logic              b_take,
  input  logic              x_room,
  output logic              x_write,
  output logic [DATA_W-1:0] x_data,
  input  logic              y_room,
  output logic              y_write,
  output logic [DATA_W-1:0] y_data,
  output logic [CNT_W-1:0]  hit_count
);
  logic a_dst, b_dst, a_flag, b_flag;
  logic a_fits, b_fits, b_out_clash, b_cnt_clash;
  logic a_to_x, a_to_y, b_to_x, b_to_y;

  assign a_dst  = a_data[DEST_BIT];
  assign b_dst  = b_data[DEST_BIT];
  assign a_flag = a_data[FLAG_BIT];
  assign b_flag = b_data[FLAG_BIT];

  assign a_fits = a_valid && (a_dst ? y_room : x_room);
  assign b_fits = b_valid && (b_dst ? y_room : x_room);

  assign b_out_clash = a_take && (a_dst == b_dst);
  assign b_cnt_clash = a_take && a_flag && b_flag;

  assign a_take = a_fits;
  assign b_take = b_fits && !b_out_clash && !b_cnt_clash;

  assign a_to_x = a_take && !a_dst;
  assign a_to_y = a_take &&  a_dst;
  assign b_to_x = b_take && !b_dst;
  assign b_to_y = b_take &&  b_dst;

  assign x_write = a_to_x || b_to_x;
  assign y_write = a_to_y || b_to_y;
  assign x_data  = a_to_x ? a_data : b_data;
  assign y_data  = a_to_y ? a_data : b_data;

  always_ff @(posedge clk) begin
    if (!rst_n)
      hit_count <= '0;
    else if ((a_take && a_flag) || (b_take && b_flag))
      hit_count <= hit_count + 1'b1;
  end
endmodule

// File: rtl/pkt_switch2x2_chk.sv
module pkt_switch2x2_chk #(
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int DEST_BIT = 0,
  parameter int FLAG_BIT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_valid,
  input logic [DATA_W-1:0] a_data,
  input logic              a_take,
  input logic              b_valid,
  input logic [DATA_W-1:0] b_data,
  input logic              b_take,
  input logic              x_room,
  input logic              x_write,
  input logic [DATA_W-1:0] x_data,
  input logic              y_room,
  input logic              y_write,
  input logic [DATA_W-1:0] y_data,
  input logic [CNT_W-1:0]  hit_count
);
  logic [1:0] n_hits;
  assign n_hits = 2'(a_take && a_data[FLAG_BIT]) + 2'(b_take && b_data[FLAG_BIT]);

  AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (a_take |-> a_valid) and (b_take |-> b_valid)); // R3
  AST_NO_FULL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (x_write |-> x_room) and (y_write |-> y_room)); // R3
  AST_IN1_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && (a_data[DEST_BIT] ? y_room : x_room)) |-> a_take); // R4
  AST_ONE_PER_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (a_take && b_take) |-> (a_data[DEST_BIT] != b_data[DEST_BIT])); // R5
  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (a_take && b_take) |-> !(a_data[FLAG_BIT] && b_data[FLAG_BIT])); // R6
  AST_POP_PUSH_A: assert property (@(posedge clk) disable iff (!rst_n)
    a_take |-> (a_data[DEST_BIT] ? (y_write && y_data == a_data)
                                 : (x_write && x_data == a_data))); // R8
  AST_POP_PUSH_B: assert property (@(posedge clk) disable iff (!rst_n)
    b_take |-> (b_data[DEST_BIT] ? (y_write && y_data == b_data)
                                 : (x_write && x_data == b_data))); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> hit_count == $past(hit_count) + CNT_W'($past(n_hits))); // R2
endmodule

bind pkt_switch2x2 pkt_switch2x2_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .DEST_BIT(DEST_BIT), .FLAG_BIT(FLAG_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_valid(a_valid), .a_data(a_data), .a_take(a_take),
  .b_valid(b_valid), .b_data(b_data), .b_take(b_take),
  .x_room(x_room), .x_write(x_write), .x_data(x_data),
  .y_room(y_room), .y_write(y_write), .y_data(y_data),
  .hit_count(hit_count)
);

// File: tb/test_pkt_switch2x2.sv
`timescale 1ns/1ps
module test_pkt_switch2x2;
  localparam int DW = 32;
  localparam int CW = 4;

  logic clk = 0, rst_n = 0;
  logic a_valid = 0, b_valid = 0, x_room = 0, y_room = 0;
  logic [DW-1:0] a_data = '0, b_data = '0;
  logic a_take, b_take, x_write, y_write;
  logic [DW-1:0] x_data, y_data;
  logic [CW-1:0] hit_count;

  int n_run = 0, n_fail = 0;
  int exp_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pkt_switch2x2 #(.DATA_W(DW), .CNT_W(CW)) i_pkt_switch2x2 (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_data(a_data), .a_take(a_take),
    .b_valid(b_valid), .b_data(b_data), .b_take(b_take),
    .x_room(x_room), .x_write(x_write), .x_data(x_data),
    .y_room(y_room), .y_write(y_write), .y_data(y_data),
    .hit_count(hit_count)
  );

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Packet builder: bit0 = destination (0 -> x, 1 -> y), bit1 = counted flag
  function automatic logic [DW-1:0] pkt(logic [DW-3:0] tag, logic flag, logic dst);
    return {tag, flag, dst};
  endfunction

  task automatic step(string req,
                      logic av, logic [DW-1:0] ad, logic bv, logic [DW-1:0] bd,
                      logic xr, logic yr,
                      logic e_at, logic e_bt,
                      logic e_xw, logic [DW-1:0] e_xd,
                      logic e_yw, logic [DW-1:0] e_yd,
                      int inc);
    @(negedge clk);
    a_valid = av; a_data = ad; b_valid = bv; b_data = bd;
    x_room = xr; y_room = yr;
    #1;
    chk({req, " a_take"}, DW'(a_take), DW'(e_at));
    chk({req, " b_take"}, DW'(b_take), DW'(e_bt));
    chk({req, " x_write"}, DW'(x_write), DW'(e_xw));
    chk({req, " y_write"}, DW'(y_write), DW'(e_yw));
    if (e_xw) chk({req, " x_data"}, x_data, e_xd);
    if (e_yw) chk({req, " y_data"}, y_data, e_yd);
    exp_cnt = (exp_cnt + inc) % (1 << CW);
    @(posedge clk); #1;
    chk({req, " count"}, DW'(hit_count), DW'(exp_cnt));
    a_valid = 0; b_valid = 0;
  endtask

  task automatic t_reset;
    chk("R9 reset count", DW'(hit_count), 0);
    step("R3 idle", 0, '0, 0, '0, 1, 1, 0, 0, 0, '0, 0, '0, 0);
  endtask

  task automatic t_route;
    step("R1 a to x", 1, pkt(30'h11, 0, 0), 0, '0, 1, 1, 1, 0, 1, pkt(30'h11, 0, 0), 0, '0, 0);
    step("R1 a to y", 1, pkt(30'h12, 0, 1), 0, '0, 1, 1, 1, 0, 0, '0, 1, pkt(30'h12, 0, 1), 0);
    step("R8 b to x", 0, '0, 1, pkt(30'h13, 0, 0), 1, 1, 0, 1, 1, pkt(30'h13, 0, 0), 0, '0, 0);
    step("R8 b to y", 0, '0, 1, pkt(30'h14, 1, 1), 1, 1, 0, 1, 0, '0, 1, pkt(30'h14, 1, 1), 1);
  endtask

  task automatic t_full;
    step("R3 a x full", 1, pkt(30'h21, 1, 0), 0, '0, 0, 1, 0, 0, 0, '0, 0, '0, 0);
    step("R3 b y full", 0, '0, 1, pkt(30'h22, 1, 1), 1, 0, 0, 0, 0, '0, 0, '0, 0);
  endtask

  task automatic t_out_clash;
    step("R5 both to x", 1, pkt(30'h31, 0, 0), 1, pkt(30'h32, 0, 0), 1, 1,
         1, 0, 1, pkt(30'h31, 0, 0), 0, '0, 0);
    step("R5 both to y", 1, pkt(30'h33, 1, 1), 1, pkt(30'h34, 0, 1), 1, 1,
         1, 0, 0, '0, 1, pkt(30'h33, 1, 1), 1);
  endtask

  task automatic t_cnt_clash;
    step("R6 both flagged", 1, pkt(30'h41, 1, 1), 1, pkt(30'h42, 1, 0), 1, 1,
         1, 0, 0, '0, 1, pkt(30'h41, 1, 1), 1);
  endtask

  task automatic t_parallel;
    step("R7 both move", 1, pkt(30'h51, 0, 0), 1, pkt(30'h52, 0, 1), 1, 1,
         1, 1, 1, pkt(30'h51, 0, 0), 1, pkt(30'h52, 0, 1), 0);
    step("R2 one flagged", 1, pkt(30'h53, 0, 1), 1, pkt(30'h54, 1, 0), 1, 1,
         1, 1, 1, pkt(30'h54, 1, 0), 1, pkt(30'h53, 0, 1), 1);
    step("R7 a blocked b moves", 1, pkt(30'h55, 1, 0), 1, pkt(30'h56, 1, 1), 0, 1,
         0, 1, 0, '0, 1, pkt(30'h56, 1, 1), 1);
    step("R4 a moves b blocked", 1, pkt(30'h57, 0, 1), 1, pkt(30'h58, 0, 0), 0, 1,
         1, 0, 0, '0, 1, pkt(30'h57, 0, 1), 0);
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 18; i++)
      step("R9 wrap", 1, pkt(30'(i), 1, i[0]), 0, '0, 1, 1,
           1, 0, !i[0], pkt(30'(i), 1, 0), i[0], pkt(30'(i), 1, 1), 1);
    chk("R9 wrapped value", DW'(hit_count), DW'(((exp_cnt))));
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_route();
    t_full();
    t_out_clash();
    t_cnt_clash();
    t_parallel();
    t_wrap();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule